// File: doc/BRIEF.md
# Packed-BCD Ripple Adder/Subtractor

This block adds or subtracts two packed BCD words, one decimal digit per four bits, and returns a packed BCD result with a decimal carry or borrow. Every digit is handled by its own slice, which is built around one 4-bit binary adder. Before the adder, the slice offsets the B digit. In add mode the offset is B plus six. In subtract mode the slice uses the fifteen's complement of B. After the adder, a multiplexer takes the adder's carry out of bit 3 as its select. With a carry, the raw sum goes through unchanged. Without one, six is taken off the sum, modulo 16. The carry out of bit 3 is also the slice's decimal carry-out, so the slices chain in ripple fashion from the least significant digit upward.

The word result and the final carry are held in output registers. These load on every clock edge and are cleared by a synchronous active-high reset. The digit count is a parameter.

Top module: `bcd_chain_top`

## Requirements
- R1: With `sub_en`=0, the carry input is active-high. For BCD digits (0-9), the word result is (A + B + `cin`) mod 10^N, and `cout` is 1 exactly when A + B + `cin` >= 10^N. Each digit's carry to the next digit is 1 exactly when its digit sum, including its carry-in, is at least 10.
- R2: With `sub_en`=1, the carry input and `cout` are an active-low borrow (1 = no borrow). For BCD digits, the result is (A - B - (1 - `cin`)) mod 10^N, and `cout` is 1 exactly when that difference is not negative.
- R3: A single subtracting digit with A=9, B=0, carry-in 1 yields 9 with carry-out 1. With A=1, B=2, carry-in 1, it yields 9 with carry-out 0.
- R4: Digit k takes its carry-in from the carry-out of digit k-1, and digit 0 takes `cin`. A carry or borrow therefore ripples across every digit of the word: 9999+0001 gives 0000 with `cout`=1, and 0000-0001 gives 9999 with `cout`=0.
- R5: When the binary adder of a digit produces no carry, six is subtracted modulo 16 from its sum, for example 0+0+0 in add mode gives digit 0. When the adder does carry, the sum passes unchanged, for example 5+5 gives digit 0 with carry 1. The correction never alters the carry.
- R6: While `rst` is 1 at a rising clock edge, `q_out` becomes all zeros and `cout` becomes 0 after that edge.
- R7: `q_out` and `cout` change only at rising clock edges. They show the result of the inputs present at the previous edge.
- R8: For digit codes 10-15 the result is deterministic. The adder sum is s = A + ((B + 6) mod 16) + carry-in when adding, or s = A + (15 - B) + carry-in when subtracting. The carry is s >= 16. The digit is s mod 16 if the adder carries, otherwise (s - 6) mod 16. So 000F+000F with `cin`=0 gives 0014, and 000A-000C with `cin`=1 gives 9998 with `cout`=0.
- R9: For BCD inputs, every result digit is in the range 0-9 in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; outputs register on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| sub_en | input | 1 | 0 = add, 1 = subtract |
| cin | input | 1 | Carry in (add) or active-low borrow in (subtract) for digit 0 |
| a_in | input | 4*NUM_DIGITS | Packed BCD operand A, digit 0 in bits 3:0 |
| b_in | input | 4*NUM_DIGITS | Packed BCD operand B, digit 0 in bits 3:0 |
| q_out | output | 4*NUM_DIGITS | Registered packed BCD result |
| cout | output | 1 | Registered carry (add) or active-low borrow (subtract) out of the top digit |

## Verification
Add mode is tried with several kinds of operands. Zero plus zero exercises the minus-six path. Sums of exactly ten exercise the pass-through path. All-nines plus one makes a carry ripple across every digit, and a long stream of pseudo-random BCD words covers mixed digit carries. Subtract mode uses both worked digit examples, zero minus zero with a borrow in, and a difference of one across a digit boundary. These separate the two borrow polarities and show whether a borrow chain breaks. Non-decimal codes check that the pre-bias wraps modulo 16 as specified, and a change of inputs between edges shows that the outputs only move at the clock.

// File: rtl/bcd_slice_pkg.sv
package bcd_slice_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] digit_t;
  localparam digit_t BIAS_SIX = digit_t'(6);
  localparam digit_t DIGIT_MAX = digit_t'(9);

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } arith_op_e;
endpackage

// File: rtl/bcd_operand_bias.sv
module bcd_operand_bias
  import bcd_slice_pkg::*;
(
  input  arith_op_e op,
  input  digit_t    b_raw,
  output digit_t    b_biased
);
  // Add: fold the +6 decimal correction in ahead of the adder.
  // Subtract: fifteen's complement, i.e. nine's complement plus six.
  always_comb begin
    if (op == OP_SUB) b_biased = ~b_raw;
    else              b_biased = b_raw + BIAS_SIX;
  end
endmodule

// File: rtl/bcd_digit_adder.sv
module bcd_digit_adder
  import bcd_slice_pkg::*;
(
  input  digit_t a_dig,
  input  digit_t b_dig,
  input  logic   c_in,
  output digit_t sum,
  output logic   c_out
);
  logic [DIGIT_W:0] full;

  always_comb begin
    full  = {1'b0, a_dig} + {1'b0, b_dig} + {{DIGIT_W{1'b0}}, c_in};
    sum   = full[DIGIT_W-1:0];
    c_out = full[DIGIT_W];
  end
endmodule

// File: rtl/bcd_result_select.sv
module bcd_result_select
  import bcd_slice_pkg::*;
(
  input  digit_t raw_sum,
  input  logic   adder_carry,
  output digit_t q_dig
);
  digit_t corrected;

  // Undo the pre-bias when the adder did not reach 0x10 (mod 16).
  always_comb begin
    corrected = raw_sum - BIAS_SIX;
    q_dig     = adder_carry ? raw_sum : corrected;
  end
endmodule

// File: rtl/bcd_digit_slice.sv
module bcd_digit_slice
  import bcd_slice_pkg::*;
(
  input  arith_op_e op,
  input  digit_t    a_dig,
  input  digit_t    b_dig,
  input  logic      c_in,
  output digit_t    q_dig,
  output logic      c_out
);
  digit_t b_biased;
  digit_t raw_sum;
  logic   adder_carry;

  bcd_operand_bias i_bias (
    .op       (op),
    .b_raw    (b_dig),
    .b_biased (b_biased)
  );

  bcd_digit_adder i_adder (
    .a_dig (a_dig),
    .b_dig (b_biased),
    .c_in  (c_in),
    .sum   (raw_sum),
    .c_out (adder_carry)
  );

  bcd_result_select i_select (
    .raw_sum     (raw_sum),
    .adder_carry (adder_carry),
    .q_dig       (q_dig)
  );

  // The carry out of bit 3 is the decimal carry; correction never touches it.
  assign c_out = adder_carry;
endmodule

// File: rtl/bcd_chain_top.sv
module bcd_chain_top
  import bcd_slice_pkg::*;
#(
  parameter int NUM_DIGITS = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          sub_en,
  input  logic                          cin,
  input  logic [DIGIT_W*NUM_DIGITS-1:0] a_in,
  input  logic [DIGIT_W*NUM_DIGITS-1:0] b_in,
  output logic [DIGIT_W*NUM_DIGITS-1:0] q_out,
  output logic                          cout
);
  localparam int WORD_W = DIGIT_W * NUM_DIGITS;

  arith_op_e          op;
  logic [NUM_DIGITS:0] carry;
  logic [WORD_W-1:0]  q_next;

  assign op       = sub_en ? OP_SUB : OP_ADD;
  assign carry[0] = cin;

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
    digit_t a_k;
    digit_t b_k;
    digit_t q_k;

    assign a_k = a_in[k*DIGIT_W +: DIGIT_W];
    assign b_k = b_in[k*DIGIT_W +: DIGIT_W];

    bcd_digit_slice i_slice (
      .op    (op),
      .a_dig (a_k),
      .b_dig (b_k),
      .c_in  (carry[k]),
      .q_dig (q_k),
      .c_out (carry[k+1])
    );

    assign q_next[k*DIGIT_W +: DIGIT_W] = q_k;

    // R1: add-mode digit carry follows the decimal sum threshold.
    assert_add_carry_R1 : assert property (@(posedge clk) disable iff (rst)
      (!sub_en && a_k <= DIGIT_MAX && b_k <= DIGIT_MAX) |->
        (carry[k+1] == (({1'b0, a_k} + {1'b0, b_k} + {4'd0, carry[k]}) >= 5'd10)));

    // R2: subtract-mode carry is 1 exactly when no borrow is owed.
    assert_sub_borrow_R2 : assert property (@(posedge clk) disable iff (rst)
      (sub_en && a_k <= DIGIT_MAX && b_k <= DIGIT_MAX) |->
        (carry[k+1] == (({1'b0, a_k} + {4'd0, carry[k]}) >= ({1'b0, b_k} + 5'd1))));

    // R3: worked subtract example, 9 - 0 with no borrow in.
    assert_sub_nine_R3 : assert property (@(posedge clk) disable iff (rst)
      (sub_en && a_k == 4'd9 && b_k == 4'd0 && carry[k]) |->
        (q_k == 4'd9 && carry[k+1]));

    // R9: decimal inputs always give a decimal digit.
    assert_digit_valid_R9 : assert property (@(posedge clk) disable iff (rst)
      (a_k <= DIGIT_MAX && b_k <= DIGIT_MAX) |-> (q_k <= DIGIT_MAX));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_out <= '0;
      cout  <= 1'b0;
    end else begin
      q_out <= q_next;
      cout  <= carry[NUM_DIGITS];
    end
  end

  // R6: reset clears the registered outputs on the following cycle.
  assert_reset_clear_R6 : assert property (@(posedge clk)
    rst |=> (q_out == '0 && !cout));

  // R7: outputs hold between edges when the next value is unchanged.
  assert_hold_stable_R7 : assert property (@(posedge clk) disable iff (rst)
    ($stable(q_out) && $stable(q_next) && $stable(carry[NUM_DIGITS]) && !$past(rst))
      |=> $stable(q_out));
endmodule

// File: tb/test_bcd_chain_top.sv
module test_bcd_chain_top;
  localparam int N  = 4;
  localparam int W  = 4 * N;
  localparam int MODV = 10000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sub_en = 1'b0;
  logic         cin = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic [W-1:0] q_out;
  logic         cout;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int unsigned seed = 32'h1234_5678;

  always #5 clk = ~clk;

  bcd_chain_top #(.NUM_DIGITS(N)) i_bcd_chain_top (
    .clk(clk), .rst(rst), .sub_en(sub_en), .cin(cin),
    .a_in(a_in), .b_in(b_in), .q_out(q_out), .cout(cout)
  );

  function automatic int from_bcd(input logic [W-1:0] v);
    int r = 0;
    for (int k = N - 1; k >= 0; k--) r = r * 10 + int'(v[k*4 +: 4]);
    return r;
  endfunction

  function automatic logic [W-1:0] to_bcd(input int v);
    logic [W-1:0] r = '0;
    int t = v;
    for (int k = 0; k < N; k++) begin
      r[k*4 +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] exp_q, input logic exp_c);
    checks++;
    if (q_out !== exp_q || cout !== exp_c) begin
      errors++;
      $display("FAIL %s: got q=%h cout=%b, expected q=%h cout=%b", req, q_out, cout, exp_q, exp_c);
    end
  endtask

  // Apply operands between edges, check one edge later.
  task automatic apply(input logic s, input logic c, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    sub_en = s; cin = c; a_in = a; b_in = b;
    @(negedge clk);
  endtask

  task automatic run_word(input string req, input logic s, input logic c, input int a, input int b);
    int total;
    logic ec;
    apply(s, c, to_bcd(a), to_bcd(b));
    if (!s) begin
      total = a + b + int'(c);
      ec = (total >= MODV);
      total = total % MODV;
    end else begin
      total = a - b - (1 - int'(c));
      ec = (total >= 0);
      if (total < 0) total += MODV;
    end
    check(req, to_bcd(total), ec);
  endtask

  task automatic test_reset;
    rst = 1'b1;
    a_in = 16'h9999; b_in = 16'h9999; cin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R6 reset clears outputs", '0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic test_add_directed;
    run_word("R5 add 0+0 minus-six path", 1'b0, 1'b0, 0, 0);
    run_word("R5 add 5+5 pass-through", 1'b0, 1'b0, 5, 5);
    run_word("R1 add 1234+5678", 1'b0, 1'b0, 1234, 5678);
    run_word("R4 add 9999+0001 ripple", 1'b0, 1'b0, 9999, 1);
    run_word("R1 add 9999+9999+1", 1'b0, 1'b1, 9999, 9999);
  endtask

  task automatic test_sub_directed;
    run_word("R3 sub 9-0 no borrow", 1'b1, 1'b1, 9, 0);
    run_word("R3 sub 1-2 borrow", 1'b1, 1'b1, 1, 2);
    run_word("R4 sub 0000-0001 ripple", 1'b1, 1'b1, 0, 1);
    run_word("R2 sub 0-0 borrow in", 1'b1, 1'b0, 0, 0);
    run_word("R2 sub 5000-4999", 1'b1, 1'b1, 5000, 4999);
  endtask

  task automatic test_sweep;
    for (int i = 0; i < 60; i++) begin
      int a, b;
      logic s, c;
      seed = seed * 32'd1664525 + 32'd1013904223;
      a = int'(seed % 32'd10000);
      seed = seed * 32'd1664525 + 32'd1013904223;
      b = int'(seed % 32'd10000);
      s = seed[20];
      c = seed[24];
      run_word(s ? "R2 sub sweep" : "R1 add sweep", s, c, a, b);
    end
  endtask

  task automatic test_non_bcd;
    apply(1'b0, 1'b0, 16'h000F, 16'h000F);
    check("R8 add F+F", 16'h0014, 1'b0);
    apply(1'b1, 1'b1, 16'h000A, 16'h000C);
    check("R8 sub A-C", 16'h9998, 1'b0);
  endtask

  task automatic test_hold;
    apply(1'b0, 1'b0, to_bcd(1111), to_bcd(2222));
    check("R7 first result", to_bcd(3333), 1'b0);
    a_in = to_bcd(4000);
    #2;
    check("R7 hold before edge", to_bcd(3333), 1'b0);
    @(negedge clk);
    check("R7 update after edge", to_bcd(6222), 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_add_directed();
    test_sub_directed();
    test_non_bcd();
    test_hold();
    test_sweep();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule